// File: doc/BRIEF.md
# Modem Control and Status Unit with Loopback

This unit holds the modem control state and the modem status state of a 16550-compatible serial port. Four asynchronous handshake inputs (carrier detect, ring, data-set-ready, clear-to-send) are brought into the clock domain. The unit records their current levels and raises a sticky change flag for each one. A read of the status byte returns its value and clears the change flags. The control byte drives the four handshake outputs.

A loopback bit in the control byte turns the port back on itself. The status levels then come from the control bits rather than from the pins. The external handshake outputs go inactive. The serial output pin idles high, and the transmitter's serial stream is fed to the receiver input. An any-change flag goes to the interrupt logic, which sits outside this unit together with the data path.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset the control byte reads 0x08, with only the OUT2 bit (bit 3) set. The status byte reads 0xB0, meaning carrier, data-set-ready and clear-to-send are high, ring is low and no change flag is set. out2_out is 1, the other handshake outputs are 0, and any_delta is 0.
- R2: Each handshake input passes through two synchronizing flops. A level applied before clock edge k shows in the status byte after edge k+2 and not after edge k+1.
- R3: Status bits [7:4] are carrier, ring, data-set-ready and clear-to-send. Any change of bit 7, 5 or 4 sets change flag bit 3, 1 or 0 respectively.
- R4: Change flag bit 2 sets only when the ring level falls from 1 to 0. A rise leaves it clear.
- R5: A status read (msr_re high for one cycle) returns the current byte. The cycle after, bits [3:0] are zero unless a new change arrived.
- R6: A change that lands in the same clock edge as a status read stays set after that read.
- R7: A control write keeps only wdata[4:0]: bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR. Read back shows bits [7:5] as zero.
- R8: Outside loopback, rts_out, dtr_out, out1_out and out2_out follow their control bits. txd_pad follows txd_core, and rxd_core follows rxd_pad.
- R9: In loopback, status bits [7:4] read OUT2, OUT1, DTR and RTS respectively. Changes in them set change flags under the same rules as R3 and R4.
- R10: In loopback, all four handshake outputs are 0 and txd_pad is 1. rxd_core equals txd_core. The external handshake inputs and rxd_pad have no effect on the status byte or on rxd_core.
- R11: any_delta is high exactly when any of status bits [3:0] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_we | input | 1 | Control byte write strobe |
| mcr_wdata | input | 8 | Control byte write data |
| mcr_rdata | output | 8 | Control byte read data |
| msr_re | input | 1 | Status byte read strobe (clears change flags) |
| msr_rdata | output | 8 | Status byte read data |
| dcd_in | input | 1 | Carrier detect pin, asynchronous |
| ri_in | input | 1 | Ring pin, asynchronous |
| dsr_in | input | 1 | Data-set-ready pin, asynchronous |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| rts_out | output | 1 | Request-to-send pin |
| dtr_out | output | 1 | Data-terminal-ready pin |
| out1_out | output | 1 | User output 1 pin |
| out2_out | output | 1 | User output 2 pin |
| txd_core | input | 1 | Serial stream from the transmitter |
| txd_pad | output | 1 | Serial output pin |
| rxd_pad | input | 1 | Serial input pin |
| rxd_core | output | 1 | Serial stream to the receiver |
| any_delta | output | 1 | Any change flag set |

## Verification
The embedded properties watch several rules on every cycle. The ring flag may rise only on a falling ring level. Each observed level change must leave its flag set. A read with no new change must clear the flags. In loopback, the pins must go quiet, the serial path must turn around, and the status nibble must mirror the control bits. Other behaviour shows only in the bench scenarios. These cover the exact two-flop latency, a change colliding with a read, masking of unused control bits, pins ignored in loopback, and a long random sequence of input levels with reads at random points.

// File: rtl/modem_pkg.sv
package modem_pkg;
    // control byte fields; bit positions are visible to software
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    localparam int unsigned CTL_W   = 5;
    localparam int unsigned LINES   = 4;   // {carrier, ring, dsr, cts}
    localparam int unsigned RING_IX = 2;
    localparam logic [LINES-1:0] LINES_RST = 4'b1011;
    localparam ctl_t CTL_RST = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] stage_d, stage_q;

        always_comb begin
            stage_d = {stage_q[0], async_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{RST_VAL[i]}};
            else        stage_q <= stage_d;
        end

        assign sync_out[i] = stage_q[1];
    end
endmodule

// File: rtl/modem_status.sv
module modem_status
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] src_lvl,
    input  logic             rd_clr,
    output logic [LINES-1:0] lvl_q_o,
    output logic [LINES-1:0] chg_q_o
);
    typedef struct packed {
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] chg;
    } st_t;

    st_t st_d, st_q;
    logic [LINES-1:0] evt;

    always_comb begin
        evt          = st_q.lvl ^ src_lvl;
        // ring flag only on the falling edge
        evt[RING_IX] = st_q.lvl[RING_IX] & ~src_lvl[RING_IX];
        st_d.lvl     = src_lvl;
        st_d.chg     = (rd_clr ? '0 : st_q.chg) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: LINES_RST, chg: '0};
        else        st_q <= st_d;
    end

    assign lvl_q_o = st_q.lvl;
    assign chg_q_o = st_q.chg;

    // R4
    ring_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.chg[RING_IX]) |-> ($past(st_q.lvl[RING_IX]) && !st_q.lvl[RING_IX]));

    // R3
    change_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |->
        ((st_q.chg & (st_q.lvl ^ $past(st_q.lvl)) & 4'b1011) == ((st_q.lvl ^ $past(st_q.lvl)) & 4'b1011)));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (src_lvl == st_q.lvl)) |=> (st_q.chg == '0));
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
    import modem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mcr_we,
    input  logic [7:0] mcr_wdata,
    output logic [7:0] mcr_rdata,
    input  logic       msr_re,
    output logic [7:0] msr_rdata,
    input  logic       dcd_in,
    input  logic       ri_in,
    input  logic       dsr_in,
    input  logic       cts_in,
    output logic       rts_out,
    output logic       dtr_out,
    output logic       out1_out,
    output logic       out2_out,
    input  logic       txd_core,
    output logic       txd_pad,
    input  logic       rxd_pad,
    output logic       rxd_core,
    output logic       any_delta
);
    ctl_t ctl_d, ctl_q;
    logic [LINES-1:0] pin_lvl, loop_lvl, src_lvl, lvl_q, chg_q;

    always_comb begin
        ctl_d = ctl_q;
        if (mcr_we) ctl_d = ctl_t'(mcr_wdata[CTL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    modem_sync #(.WIDTH(LINES), .RST_VAL(LINES_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({dcd_in, ri_in, dsr_in, cts_in}),
        .sync_out(pin_lvl)
    );

    // loopback cross-map: OUT2->carrier, OUT1->ring, DTR->dsr, RTS->cts
    assign loop_lvl = {ctl_q.out2, ctl_q.out1, ctl_q.dtr, ctl_q.rts};
    assign src_lvl  = ctl_q.loop ? loop_lvl : pin_lvl;

    modem_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_lvl(src_lvl),
        .rd_clr (msr_re),
        .lvl_q_o(lvl_q),
        .chg_q_o(chg_q)
    );

    assign mcr_rdata = {{(8-CTL_W){1'b0}}, ctl_q};
    assign msr_rdata = {lvl_q, chg_q};
    assign any_delta = |chg_q;

    assign rts_out  = ctl_q.rts  & ~ctl_q.loop;
    assign dtr_out  = ctl_q.dtr  & ~ctl_q.loop;
    assign out1_out = ctl_q.out1 & ~ctl_q.loop;
    assign out2_out = ctl_q.out2 & ~ctl_q.loop;
    assign txd_pad  = ctl_q.loop ? 1'b1 : txd_core;
    assign rxd_core = ctl_q.loop ? txd_core : rxd_pad;

    // R10
    loop_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> (!rts_out && !dtr_out && !out1_out && !out2_out && txd_pad && (rxd_core == txd_core)));

    // R9
    loop_status_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_rdata[4] && $past(mcr_rdata[4]) && $stable(mcr_rdata)) |->
        (msr_rdata[7:4] == {mcr_rdata[3], mcr_rdata[2], mcr_rdata[0], mcr_rdata[1]}));

    // R11
    any_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_delta == (msr_rdata[3:0] != 4'h0));
endmodule

// File: tb/sim_uart_modem_ctrl.sv
module sim_uart_modem_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mcr_we = 1'b0;
    logic [7:0] mcr_wdata = 8'h00;
    logic msr_re = 1'b0;
    logic [3:0] pins = 4'b1011;   // {dcd, ri, dsr, cts}
    logic txd_core = 1'b1, rxd_pad = 1'b1;
    logic [7:0] mcr_rdata, msr_rdata;
    logic rts_out, dtr_out, out1_out, out2_out, txd_pad, rxd_core, any_delta;

    int checks = 0, errors = 0;
    logic [3:0] exp_lvl = 4'b1011, exp_chg = 4'h0;

    always #10 clk = ~clk;

    uart_modem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata), .mcr_rdata(mcr_rdata),
        .msr_re(msr_re), .msr_rdata(msr_rdata),
        .dcd_in(pins[3]), .ri_in(pins[2]), .dsr_in(pins[1]), .cts_in(pins[0]),
        .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out), .out2_out(out2_out),
        .txd_core(txd_core), .txd_pad(txd_pad), .rxd_pad(rxd_pad), .rxd_core(rxd_core),
        .any_delta(any_delta)
    );

    function automatic logic [3:0] chg_of(input logic [3:0] o, input logic [3:0] n);
        return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle_to(input logic [3:0] n);
        exp_chg |= chg_of(exp_lvl, n);
        exp_lvl = n;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_status(input string req);
        @(negedge clk);
        check(req, msr_rdata, {exp_lvl, exp_chg});
        check({req, " any_delta"}, {7'd0, any_delta}, {7'd0, exp_chg != 4'h0});
        msr_re = 1'b1;
        @(negedge clk);
        msr_re = 1'b0;
        exp_chg = 4'h0;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        mcr_we = 1'b1;
        mcr_wdata = v;
        @(negedge clk);
        mcr_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctl", mcr_rdata, 8'h08);
        check("R1 status", msr_rdata, 8'hB0);
        check("R1 pins", {4'd0, rts_out, dtr_out, out1_out, out2_out}, 8'h01);
        check("R1 any_delta", {7'd0, any_delta}, 8'h00);

        // R2 latency: change before edge k, visible after k+2 only
        @(negedge clk);
        pins = 4'b1010;           // cts falls
        @(negedge clk); @(negedge clk);
        check("R2 not yet", msr_rdata, 8'hB0);
        @(negedge clk);
        settle_to(4'b1010);
        check("R2 visible", msr_rdata, {exp_lvl, exp_chg});

        // R3 / R11 / R5
        set_pins(4'b0000); settle_to(4'b0000);
        read_status("R3 carrier dsr cts change");
        read_status("R5 cleared after read");

        // R4 ring rise then fall
        set_pins(4'b0100); settle_to(4'b0100);
        read_status("R4 ring rise no flag");
        set_pins(4'b0000); settle_to(4'b0000);
        read_status("R4 ring fall flag");

        // R6 change colliding with read
        @(negedge clk);
        pins = 4'b0001;
        @(negedge clk); @(negedge clk);
        msr_re = 1'b1;
        @(negedge clk);
        msr_re = 1'b0;
        exp_chg = 4'h0;
        settle_to(4'b0001);
        check("R6 change survives read", msr_rdata, {exp_lvl, exp_chg});
        read_status("R6 follow-up");

        // R7 / R8 normal mode outputs
        write_ctl(8'hE7);
        check("R7 masked readback", mcr_rdata, 8'h07);
        check("R8 pins follow", {4'd0, rts_out, dtr_out, out1_out, out2_out}, 8'h0E);
        txd_core = 1'b0; rxd_pad = 1'b0;
        @(negedge clk);
        check("R8 serial pass", {6'd0, txd_pad, rxd_core}, 8'h00);
        txd_core = 1'b1; rxd_pad = 1'b1;

        // R9 / R10 loopback: out1=1 rts=1 -> lvl {0,1,0,1}
        write_ctl(8'h16);
        settle_to(4'b0101);
        check("R10 pins quiet", {4'd0, rts_out, dtr_out, out1_out, out2_out}, 8'h00);
        txd_core = 1'b0; rxd_pad = 1'b1;
        @(negedge clk);
        check("R10 turnaround", {6'd0, txd_pad, rxd_core}, 8'h02);
        txd_core = 1'b1; rxd_pad = 1'b0;
        @(negedge clk);
        check("R10 rxd_pad ignored", {6'd0, txd_pad, rxd_core}, 8'h03);
        rxd_pad = 1'b1;
        read_status("R9 loop map");
        set_pins(4'b1110);
        read_status("R10 pins ignored");
        write_ctl(8'h1B);          // out2 dtr rts -> {1,0,1,1}
        settle_to(4'b1011);
        read_status("R9 loop remap");

        // leave loopback, back to pins
        write_ctl(8'h08);
        @(negedge clk);
        settle_to(pins);
        read_status("R8 back to pins");

        // random levels with random reads
        for (int i = 0; i < 60; i++) begin
            logic [3:0] n;
            n = 4'($urandom);
            set_pins(n);
            settle_to(n);
            if ($urandom % 3 == 0) read_status("R3 R4 random");
        end
        read_status("R5 random final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule